// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit virtual address using short-format page table descriptors. The requester presents a virtual address, an access kind and a privilege flag. The walker chooses one of two translation table bases from a programmable split width, then reads a first-level descriptor over a single-word memory read port. A first-level section entry ends the walk with a 1 MB mapping. A first-level table pointer starts a second-level read, which gives a 64 KB or 4 KB mapping. Ignore, reserved and invalid entries end the walk with a translation fault instead.

The result arrives with a one-cycle `done` pulse. It is either a translation entry or a fault report. The entry holds the frame base, virtual page number, size mask, global flag, domain, cacheability and the requester's privilege flag. The fault report gives the level, the abort class and the write flag. Cacheability comes from the C bit. With remap enabled it comes instead from a 3-bit index into three packed attribute fields.

Back-pressure rules: a request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the walker is idle. A `req_valid` seen while `req_ready` is low is not taken, and `busy_err` flags it in the same cycle. On the memory side, `mem_req_valid` holds with a stable address until `mem_req_ready` is seen high. Exactly one read is outstanding at a time. The response is one `mem_rsp_valid` pulse that carries the word, and the walker accepts it in any cycle.

Top module: `tblwalk_top`

## Requirements
- R1: Base register 1 is used when the split width is nonzero and any of the top split-width bits of the virtual address is set; otherwise base register 0 is used.
- R2: The first-level read address is the selected base with bits below position 14-split cleared, ORed with virtual address bits [31-split:20] placed at bit 2.
- R3: The first-level descriptor type is its bits [1:0]. 00 (ignore) and 11 (reserved) give a first-level fault with domain 0. 10 (section) completes a 1 MB entry. 01 (table) starts a second-level read.
- R4: The second-level read address is first-level descriptor bits [31:10] followed by virtual address bits [19:12] and two zero bits.
- R5: A second-level descriptor with bits [1:0] = 00 gives a second-level fault that reports the domain from bits [8:5] of the first-level descriptor.
- R6: Second-level type 01 gives a 64 KB page and type 1x gives a 4 KB page. The frame is the descriptor with its bits below the page size cleared. Global is the inverse of bit 17 for a section and of bit 11 for a page.
- R7: A completed entry carries size mask (1<<S)-1 and VPN vaddr>>S, with S equal to 20, 16 or 12. Its domain is first-level bits [8:5] and it carries the request's privilege flag.
- R8: Access kinds are 00 read, 01 write and 10 fetch. A fault on a fetch sets the instruction-abort flag with the write flag clear. Any other fault is a data abort whose write flag is set only for a write.
- R9: A request while the walker is not idle raises `busy_err` in the same cycle, is not accepted, and does not disturb the walk in progress.
- R10: With remap on, the index is {TEX[0], C, B}. Those bits are descriptor bits {12,3,2} for sections and large pages, and {6,3,2} for small pages. The region is non-cacheable when the indexed 2-bit field of `cfg_inner` is 0, the field of `cfg_outer` is 0, or the field of `cfg_type` is not 2.
- R11: With remap on, index 6 sets `out_attr_err` and marks the region non-cacheable.
- R12: With remap off, the region is non-cacheable exactly when the C bit (descriptor bit 3) is 0, and `out_attr_err` stays low.
- R13: Each walk issues one memory read per level, two at most. A read held off by `mem_req_ready` keeps its address stable.
- R14: `done` is high for exactly one cycle, and `req_ready` is high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| req_priv | input | 1 | Requester privilege flag |
| busy_err | output | 1 | Request presented while a walk is in progress |
| cfg_split | input | SPLIT_W | Split width between the two base registers |
| cfg_base0 | input | 32 | Translation base register 0 |
| cfg_base1 | input | 32 | Translation base register 1 |
| cfg_remap_en | input | 1 | Attribute remap enable |
| cfg_inner | input | 2*ATTR_SLOTS | Inner attribute fields, 2 bits per index |
| cfg_outer | input | 2*ATTR_SLOTS | Outer attribute fields, 2 bits per index |
| cfg_type | input | 2*ATTR_SLOTS | Memory type fields, 2 bits per index |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Read data pulse |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | Walk finished, result valid this cycle |
| out_fault | output | 1 | Result is a translation fault |
| out_fault_l2 | output | 1 | Fault arose at the second level |
| out_instr_abort | output | 1 | Fault is an instruction abort |
| out_write | output | 1 | Data abort on a write |
| out_domain | output | 4 | Domain of the entry or fault |
| out_frame | output | 32 | Physical frame base |
| out_vpn | output | 32 | Virtual page number |
| out_size_mask | output | 32 | Page offset mask |
| out_global | output | 1 | Mapping is global |
| out_noncache | output | 1 | Region is non-cacheable |
| out_attr_err | output | 1 | Implementation-defined remap index used |
| out_priv | output | 1 | Privilege flag of the request |

## Verification
The bench builds the walker with its defaults, `SPLIT_W` = 3 and eight attribute slots. That puts every split width from 0 to 7, both base registers and every remap index within reach of a full sweep. The sweep crosses each split width with five virtual addresses and all six descriptor outcomes: ignore, reserved, section, invalid page, large page and small page. The access kind, memory latency and ready stalls rotate across walks. Some walks carry a second request in mid-walk to probe the busy flag.

// File: rtl/tblwalk_pkg.sv
package tblwalk_pkg;
  localparam int VA_W          = 32;
  localparam int WORD_W        = 32;
  localparam int DOM_W         = 4;
  localparam int SHIFT_W       = 5;
  localparam int REMAP_IDX_W   = 3;
  localparam int BASE_LSB_MAX  = 14;
  localparam int L1_IDX_LO     = 20;
  localparam int L2_IDX_LO     = 12;
  localparam int L2_IDX_HI     = 19;
  localparam int TBL_BASE_LO   = 10;
  localparam int SECTION_SHIFT = 20;
  localparam int LARGE_SHIFT   = 16;
  localparam int SMALL_SHIFT   = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    ACC_READ = 2'b00, ACC_WRITE = 2'b01, ACC_FETCH = 2'b10, ACC_SPARE = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/tw_l1_addr.sv
module tw_l1_addr
  import tblwalk_pkg::*;
#(
  parameter int SPLIT_W = 3
) (
  input  logic [VA_W-1:0]    vaddr,
  input  logic [SPLIT_W-1:0] split,
  input  logic [WORD_W-1:0]  base0,
  input  logic [WORD_W-1:0]  base1,
  output logic               use_base1,
  output logic [WORD_W-1:0]  desc_addr
);
  logic [VA_W-1:0]   hi_mask;
  logic [VA_W-1:0]   low_va;
  logic [WORD_W-1:0] base_sel;
  logic [WORD_W-1:0] base_mask;

  always_comb begin
    hi_mask   = ~({VA_W{1'b1}} >> split);
    use_base1 = (vaddr & hi_mask) != '0;
    base_sel  = use_base1 ? base1 : base0;
    low_va    = vaddr & ~hi_mask;
    base_mask = {WORD_W{1'b1}} << (BASE_LSB_MAX - int'(split));
    desc_addr = (base_sel & base_mask) | ((low_va >> L1_IDX_LO) << 2);
  end
endmodule

// File: rtl/tw_desc_decode.sv
module tw_desc_decode
  import tblwalk_pkg::*;
(
  input  logic [WORD_W-1:0]      desc,
  input  logic                   second,
  input  logic [VA_W-1:0]        vaddr,
  output logic                   fault,
  output logic                   table_ptr,
  output logic [WORD_W-1:0]      next_addr,
  output logic [WORD_W-1:0]      size_mask,
  output logic [VA_W-1:0]        vpn,
  output logic [WORD_W-1:0]      frame,
  output logic                   global_map,
  output logic [REMAP_IDX_W-1:0] remap_idx,
  output logic [DOM_W-1:0]       domain
);
  logic [SHIFT_W-1:0] shift;

  always_comb begin
    fault      = 1'b0;
    table_ptr  = 1'b0;
    shift      = SHIFT_W'(SMALL_SHIFT);
    global_map = 1'b0;
    remap_idx  = '0;
    domain     = desc[8:5];
    next_addr  = {desc[WORD_W-1:TBL_BASE_LO], vaddr[L2_IDX_HI:L2_IDX_LO], 2'b00};
    if (!second) begin
      unique case (desc[1:0])
        2'b01: table_ptr = 1'b1;
        2'b10: begin
          shift      = SHIFT_W'(SECTION_SHIFT);
          global_map = ~desc[17];
          remap_idx  = {desc[12], desc[3:2]};
        end
        default: fault = 1'b1;
      endcase
    end else begin
      unique case (desc[1:0])
        2'b00: fault = 1'b1;
        2'b01: begin
          shift      = SHIFT_W'(LARGE_SHIFT);
          global_map = ~desc[11];
          remap_idx  = {desc[12], desc[3:2]};
        end
        default: begin
          shift      = SHIFT_W'(SMALL_SHIFT);
          global_map = ~desc[11];
          remap_idx  = {desc[6], desc[3:2]};
        end
      endcase
    end
    size_mask = (WORD_W'(1) << shift) - WORD_W'(1);
    vpn       = vaddr >> shift;
    frame     = desc & ~size_mask;
  end
endmodule

// File: rtl/tw_attr_remap.sv
module tw_attr_remap #(
  parameter int ATTR_SLOTS  = 8,
  parameter int IMPDEF_SLOT = 6,
  localparam int IDX_W      = $clog2(ATTR_SLOTS),
  localparam int FLD_W      = 2 * ATTR_SLOTS
) (
  input  logic             remap_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             c_bit,
  input  logic [FLD_W-1:0] inner,
  input  logic [FLD_W-1:0] outer,
  input  logic [FLD_W-1:0] mtype,
  output logic             noncache,
  output logic             impdef_err
);
  logic [ATTR_SLOTS-1:0] slot_nc;

  for (genvar s = 0; s < ATTR_SLOTS; s++) begin : g_slot
    assign slot_nc[s] = (inner[2*s +: 2] == 2'd0) ||
                        (outer[2*s +: 2] == 2'd0) ||
                        (mtype[2*s +: 2] != 2'd2);
  end

  logic hit_impdef;
  assign hit_impdef = (int'(idx) == IMPDEF_SLOT);

  always_comb begin
    if (remap_en) begin
      noncache   = slot_nc[idx] | hit_impdef;
      impdef_err = hit_impdef;
    end else begin
      noncache   = ~c_bit;
      impdef_err = 1'b0;
    end
  end
endmodule

// File: rtl/tblwalk_top.sv
module tblwalk_top
  import tblwalk_pkg::*;
#(
  parameter int SPLIT_W    = 3,
  parameter int ATTR_SLOTS = 8,
  localparam int FLD_W     = 2 * ATTR_SLOTS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_vaddr,
  input  logic [1:0]         req_kind,
  input  logic               req_priv,
  output logic               busy_err,
  input  logic [SPLIT_W-1:0] cfg_split,
  input  logic [31:0]        cfg_base0,
  input  logic [31:0]        cfg_base1,
  input  logic               cfg_remap_en,
  input  logic [FLD_W-1:0]   cfg_inner,
  input  logic [FLD_W-1:0]   cfg_outer,
  input  logic [FLD_W-1:0]   cfg_type,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [31:0]        mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  output logic               done,
  output logic               out_fault,
  output logic               out_fault_l2,
  output logic               out_instr_abort,
  output logic               out_write,
  output logic [3:0]         out_domain,
  output logic [31:0]        out_frame,
  output logic [31:0]        out_vpn,
  output logic [31:0]        out_size_mask,
  output logic               out_global,
  output logic               out_noncache,
  output logic               out_attr_err,
  output logic               out_priv
);
  walk_state_e          st;
  logic [VA_W-1:0]      va_q;
  acc_kind_e            kind_q;
  logic                 priv_q;
  logic [WORD_W-1:0]    addr_q;
  logic [DOM_W-1:0]     dom_q;

  logic                 l1_use_b1;
  logic [WORD_W-1:0]    l1_addr;
  logic                 dec_fault, dec_table, dec_global;
  logic [WORD_W-1:0]    dec_next, dec_mask, dec_frame;
  logic [VA_W-1:0]      dec_vpn;
  logic [REMAP_IDX_W-1:0] dec_idx;
  logic [DOM_W-1:0]     dec_dom;
  logic                 rm_nc, rm_err;

  tw_l1_addr #(.SPLIT_W(SPLIT_W)) u_l1_addr (
    .vaddr     (req_vaddr),
    .split     (cfg_split),
    .base0     (cfg_base0),
    .base1     (cfg_base1),
    .use_base1 (l1_use_b1),
    .desc_addr (l1_addr)
  );

  tw_desc_decode u_decode (
    .desc       (mem_rsp_data),
    .second     (st == ST_L2_WAIT),
    .vaddr      (va_q),
    .fault      (dec_fault),
    .table_ptr  (dec_table),
    .next_addr  (dec_next),
    .size_mask  (dec_mask),
    .vpn        (dec_vpn),
    .frame      (dec_frame),
    .global_map (dec_global),
    .remap_idx  (dec_idx),
    .domain     (dec_dom)
  );

  tw_attr_remap #(.ATTR_SLOTS(ATTR_SLOTS)) u_remap (
    .remap_en   (cfg_remap_en),
    .idx        (dec_idx),
    .c_bit      (dec_idx[1]),
    .inner      (cfg_inner),
    .outer      (cfg_outer),
    .mtype      (cfg_type),
    .noncache   (rm_nc),
    .impdef_err (rm_err)
  );

  assign req_ready     = (st == ST_IDLE);
  assign busy_err      = req_valid && (st != ST_IDLE);
  assign mem_req_valid = (st == ST_L1_REQ) || (st == ST_L2_REQ);
  assign mem_req_addr  = addr_q;
  assign done          = (st == ST_DONE);

  logic             in_l2;
  logic             finish;
  logic [DOM_W-1:0] fin_dom;
  logic             is_fetch;

  always_comb begin
    in_l2    = (st == ST_L2_WAIT);
    finish   = mem_rsp_valid && (in_l2 || ((st == ST_L1_WAIT) && !dec_table));
    is_fetch = (kind_q == ACC_FETCH);
    if (in_l2)          fin_dom = dom_q;
    else if (dec_fault) fin_dom = '0;
    else                fin_dom = dec_dom;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      va_q   <= '0;
      kind_q <= ACC_READ;
      priv_q <= 1'b0;
      addr_q <= '0;
      dom_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          kind_q <= acc_kind_e'(req_kind);
          priv_q <= req_priv;
          addr_q <= l1_addr;
          st     <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready) st <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          if (!dec_fault && dec_table) begin
            addr_q <= dec_next;
            dom_q  <= dec_dom;
            st     <= ST_L2_REQ;
          end else begin
            st <= ST_DONE;
          end
        end
        ST_L2_REQ: if (mem_req_ready) st <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) st <= ST_DONE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_fault       <= 1'b0;
      out_fault_l2    <= 1'b0;
      out_instr_abort <= 1'b0;
      out_write       <= 1'b0;
      out_domain      <= '0;
      out_frame       <= '0;
      out_vpn         <= '0;
      out_size_mask   <= '0;
      out_global      <= 1'b0;
      out_noncache    <= 1'b0;
      out_attr_err    <= 1'b0;
      out_priv        <= 1'b0;
    end else if (finish) begin
      out_fault       <= dec_fault;
      out_fault_l2    <= dec_fault && in_l2;
      out_instr_abort <= dec_fault && is_fetch;
      out_write       <= dec_fault && !is_fetch && (kind_q == ACC_WRITE);
      out_domain      <= fin_dom;
      out_frame       <= dec_fault ? '0 : dec_frame;
      out_vpn         <= dec_fault ? '0 : dec_vpn;
      out_size_mask   <= dec_fault ? '0 : dec_mask;
      out_global      <= !dec_fault && dec_global;
      out_noncache    <= !dec_fault && rm_nc;
      out_attr_err    <= !dec_fault && rm_err;
      out_priv        <= priv_q;
    end
  end
endmodule

// File: rtl/tblwalk_checker.sv
module tblwalk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        busy_err,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        done,
  input logic        out_fault,
  input logic [31:0] out_size_mask,
  input logic        out_attr_err,
  input logic        out_noncache
);
  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_busy_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |-> busy_err);

  p_take_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_done_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  p_page_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !out_fault |-> (out_size_mask == 32'h000F_FFFF) ||
                           (out_size_mask == 32'h0000_FFFF) ||
                           (out_size_mask == 32'h0000_0FFF));

  p_impdef_nc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && out_attr_err |-> out_noncache);
endmodule

bind tblwalk_top tblwalk_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .busy_err      (busy_err),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .out_fault     (out_fault),
  .out_size_mask (out_size_mask),
  .out_attr_err  (out_attr_err),
  .out_noncache  (out_noncache)
);

// File: tb/tb_tblwalk_top.sv
`timescale 1ns/1ps
module tb_tblwalk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_priv = 1'b0;
  logic        busy_err;
  logic [2:0]  cfg_split = '0;
  logic [31:0] cfg_base0 = 32'h3A5C_7FFF;
  logic [31:0] cfg_base1 = 32'hC0DE_3FFF;
  logic        cfg_remap_en = 1'b0;
  logic [15:0] cfg_inner = 16'h3DF7;
  logic [15:0] cfg_outer = 16'hFCFF;
  logic [15:0] cfg_type  = 16'hAA2A;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done, out_fault, out_fault_l2, out_instr_abort, out_write;
  logic [3:0]  out_domain;
  logic [31:0] out_frame, out_vpn, out_size_mask;
  logic        out_global, out_noncache, out_attr_err, out_priv;

  always #2.5 clk = ~clk;

  tblwalk_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_priv(req_priv),
    .busy_err(busy_err), .cfg_split(cfg_split), .cfg_base0(cfg_base0),
    .cfg_base1(cfg_base1), .cfg_remap_en(cfg_remap_en), .cfg_inner(cfg_inner),
    .cfg_outer(cfg_outer), .cfg_type(cfg_type), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
    .out_fault(out_fault), .out_fault_l2(out_fault_l2),
    .out_instr_abort(out_instr_abort), .out_write(out_write),
    .out_domain(out_domain), .out_frame(out_frame), .out_vpn(out_vpn),
    .out_size_mask(out_size_mask), .out_global(out_global),
    .out_noncache(out_noncache), .out_attr_err(out_attr_err), .out_priv(out_priv)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic [31:0] l1_word = '0, l2_word = '0;
  logic [31:0] got_addr [2];
  int n_req = 0, lat = 0, pend = 0, cyc = 0;
  bit toggle_ready = 0;

  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    got_addr[0] = '0; got_addr[1] = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      mem_req_ready = toggle_ready ? cyc[0] : 1'b1;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = (n_req == 1) ? l1_word : l2_word;
        end
      end else if (mem_req_valid && mem_req_ready) begin
        if (n_req < 2) got_addr[n_req] = mem_req_addr;
        n_req++;
        pend = lat + 1;
      end
    end
  end

  task automatic run_walk(input logic [31:0] va, input logic [1:0] kind,
                          input logic priv, input bit poke);
    int guard;
    n_req = 0;
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_priv = priv; req_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      req_vaddr = ~va; req_kind = 2'b01;
      #1;
      chk("R9 busy_err on request in flight", {31'd0, busy_err}, 32'd1);
      chk("R9 not ready in flight", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    if (!done) chk("R14 done never seen", 32'd0, 32'd1);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk("R14 done single cycle", {31'd0, done}, 32'd0);
    chk("R14 ready after done", {31'd0, req_ready}, 32'd1);
  endtask

  function automatic logic [31:0] exp_l1(input logic [31:0] va, input int n);
    longint base, v, idx;
    bit b1;
    b1   = (n != 0) && ((va >> (32 - n)) != 0);
    base = b1 ? longint'(cfg_base1) : longint'(cfg_base0);
    v    = longint'(va) % (64'd1 << (32 - n));
    idx  = v / (64'd1 << 20);
    return 32'(base - (base % (64'd1 << (14 - n))) + idx * 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  logic [31:0] vas [5] = '{32'h0000_1000, 32'h8765_4321, 32'h0FF0_3ABC,
                           32'hFFFF_F000, 32'h0123_4567};

  initial begin
    repeat (3) @(negedge clk);
    chk("R14 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R14 reset done low", {31'd0, done}, 32'd0);
    chk("R13 reset no read", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;

    for (int n = 0; n < 8; n++) begin
      cfg_split = 3'(n);
      for (int vi = 0; vi < 5; vi++) begin
        for (int t = 0; t < 6; t++) begin
          logic [31:0] va, frame, tbase, exp_mask;
          logic [1:0]  kind;
          logic [3:0]  dom;
          logic [2:0]  tex;
          logic        ng, c, b, priv;
          int          sh;
          bit          flt, l2;
          va   = vas[vi];
          kind = 2'((n + vi + t) % 3);
          dom  = 4'((n * 3 + vi + t) % 16);
          tex  = 3'((t + vi) % 8);
          ng   = vi[0]; c = n[0] ^ vi[0]; b = n[1]; priv = t[0];
          lat  = (vi + t) % 3;
          toggle_ready = vi[0];
          flt  = (t < 2) || (t == 3);
          l2   = (t >= 3);
          sh   = 20;
          frame = '0;
          tbase = {va[31:10] ^ 22'h15A5A5, 10'd0};
          l2_word = 32'hFFFF_FFFC;
          case (t)
            0: l1_word = 32'hFFFF_FFFC;
            1: l1_word = 32'h1234_5677 | 32'h3;
            2: begin
              frame   = {va[31:20] ^ 12'h5A3, 20'd0};
              l1_word = frame | (32'(ng) << 17) | (32'(tex) << 12) | (32'(dom) << 5)
                        | (32'(c) << 3) | (32'(b) << 2) | 32'h2;
            end
            default: begin
              l1_word = tbase | (32'(dom) << 5) | 32'h1;
              if (t == 4) begin
                sh      = 16;
                frame   = {va[31:16] ^ 16'h3C3C, 16'd0};
                l2_word = frame | (32'(tex) << 12) | (32'(ng) << 11)
                          | (32'(c) << 3) | (32'(b) << 2) | 32'h1;
              end else if (t == 5) begin
                sh      = 12;
                frame   = {va[31:12] ^ 20'h0F0F1, 12'd0};
                l2_word = frame | (32'(ng) << 11) | (32'(tex) << 6)
                          | (32'(c) << 3) | (32'(b) << 2) | (vi[0] ? 32'h3 : 32'h2);
              end
            end
          endcase
          run_walk(va, kind, priv, (vi == 3));
          chk("R1 R2 first-level address", got_addr[0], exp_l1(va, n));
          chk("R13 read count", 32'(n_req), l2 ? 32'd2 : 32'd1);
          if (l2)
            chk("R4 second-level address", got_addr[1], tbase + 32'({va[19:12], 2'b00}));
          chk("R3 R5 fault flag", {31'd0, out_fault}, {31'd0, flt});
          if (flt) begin
            chk("R5 fault level", {31'd0, out_fault_l2}, {31'd0, l2});
            chk("R3 R5 fault domain", {28'd0, out_domain}, l2 ? {28'd0, dom} : 32'd0);
            chk("R8 instruction abort", {31'd0, out_instr_abort}, {31'd0, kind == 2'b10});
            chk("R8 write flag", {31'd0, out_write}, {31'd0, kind == 2'b01});
          end else begin
            exp_mask = (32'd1 << sh) - 1;
            chk("R6 frame", out_frame, frame);
            chk("R6 global", {31'd0, out_global}, {31'd0, ~ng});
            chk("R7 size mask", out_size_mask, exp_mask);
            chk("R7 vpn", out_vpn, va >> sh);
            chk("R7 domain", {28'd0, out_domain}, {28'd0, dom});
            chk("R7 privilege", {31'd0, out_priv}, {31'd0, priv});
            chk("R12 cacheability from C", {31'd0, out_noncache}, {31'd0, ~c});
            chk("R12 no attr error", {31'd0, out_attr_err}, 32'd0);
            chk("R8 no abort flags", {30'd0, out_instr_abort, out_write}, 32'd0);
          end
          after_done();
        end
      end
    end

    cfg_split = '0; cfg_remap_en = 1'b1; toggle_ready = 0; lat = 1;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] ix;
      bit enc;
      ix = 3'(i);
      l1_word = 32'h0030_0000 | (32'(ix[2]) << 12) | (32'(ix[1]) << 3)
                | (32'(ix[0]) << 2) | 32'h2;
      enc = (cfg_inner[2*i +: 2] == 0) || (cfg_outer[2*i +: 2] == 0)
            || (cfg_type[2*i +: 2] != 2'd2) || (i == 6);
      run_walk(32'h0010_0000, 2'b00, 1'b0, 1'b0);
      chk("R10 remap noncache", {31'd0, out_noncache}, {31'd0, enc});
      chk("R11 remap impdef error", {31'd0, out_attr_err}, {31'd0, i == 6});
      after_done();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule